// File: doc/BRIEF.md
# Walking-Ones Memory March Engine

This engine proves that every data bit of a 64-bit-wide memory region can be set on its own, at every word, without disturbing the others. After a start pulse it makes a chain of sequential sweeps over the region. Each sweep begins at word 0 and climbs through the number of words given on `size_words`. The first sweep only seeds every word with the value 1. Each later sweep does two things at every word: it reads the word back and compares it with the bit pattern seeded by the sweep before, then it writes that pattern moved up by one bit position. A closing sweep only reads, and checks that the top bit is the one left standing.

The engine drives a single synchronous memory port: one request per cycle, and read data returned on the cycle after a read request. The first wrong word stops the whole run. The engine then reports the byte address of that word, the value it expected and the value it saw. A pass number output shows progress while the run is going. The caller must hold `size_words` stable from the start pulse until `done`.

Top module: `walk_march_engine`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `mem_req` are 0 and `pass_num` is 0.
- R2: Pass 1 issues one write per cycle, with no reads, to word indices 0, 1, …, size_words-1 in ascending order. Every write has data value 1 (only bit 0 set).
- R3: In each pass p from 2 to 64, the engine handles each word index in ascending order as follows. It issues a read (`mem_req`=1, `mem_we`=0) and compares the data returned on the next cycle with 1<<(p-2). In that same comparison cycle it writes 1<<(p-1) to the same index. A read therefore always comes before the write at the same word.
- R4: Pass 65 reads every word in ascending order, checks each against 1<<63, and issues no write.
- R5: On the first miscompare, the comparison cycle issues no request. On the next cycle the engine shows `done`=1, `busy`=0 and `fail`=1. `fail_addr` holds the word index times 8, `fail_exp` holds the expected word and `fail_obs` holds the word that was read. `pass_num` keeps the number of the failing pass. No more memory requests follow.
- R6: When all 65 passes match, `done`=1 and `fail`=0 with `pass_num`=65. The run takes 129×size_words cycles: size_words for pass 1 and 2×size_words for each later pass.
- R7: A start pulse while `busy` is 1 has no effect on the request stream or on the result.
- R8: A start with `size_words`=0 makes no memory request. On the next cycle it shows `done`=1, `fail`=0 and `pass_num`=0.
- R9: `busy` is 1 from the cycle after a start until the finishing cycle. `done` and the result stay until the next start, which clears `done` and `fail`.
- R10: While `busy`, `pass_num` gives the current pass number, from 1 to 65.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; sampled only when not busy |
| size_words | input | ADDR_W+1 | Number of 64-bit words in the region |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished; held until the next start |
| fail | output | 1 | The last run found a miscompare |
| pass_num | output | PASS_W | Current or final pass number (1..65) |
| fail_addr | output | ADDR_W+3 | Byte address of the failing word |
| fail_exp | output | DATA_W | Value expected at the failing word |
| fail_obs | output | DATA_W | Value read at the failing word |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | ADDR_W | Word index of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |

## Verification
The engine is tried against a fault-free memory with regions of one, eight and sixty-four words. These runs show that the request order, the single-bit data sequence and the 129×N cycle count are right, including the case where the first and last word are the same. Stuck-at faults are then injected on a single bit at chosen words. A stuck-low bit 0 is caught in the second pass. A stuck-high bit 40 at the last word checks that a dirty upper bit is reported. A stuck-low bit 63 is caught only by the closing read-only sweep. A stuck-low bit 20 with a stray start pulse checks both the mid-run abort pass number and that the pulse is ignored. An empty region and a restart after a failure cover the remaining control paths.

// File: rtl/walk_march_pkg.sv
package walk_march_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_READ,
    ST_CHECK,
    ST_DONE
  } march_st_t;
endpackage

// File: rtl/march_addr_ctr.sv
module march_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [ADDR_W:0]   size_words,
  output logic [ADDR_W-1:0] idx,
  output logic              at_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (step)  idx <= idx + 1'b1;
  end

  assign at_last = ({1'b0, idx} == (size_words - 1'b1));

  assert_step_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |-> ({1'b0, idx} < size_words))
    else $error("index advanced beyond the region");
endmodule

// File: rtl/march_word_cmp.sv
module march_word_cmp #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  localparam int BYTE_SH = $clog2(DATA_W / 8),
  localparam int BADDR_W = ADDR_W + BYTE_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               checking,
  input  logic [ADDR_W-1:0]  idx,
  input  logic [DATA_W-1:0]  expect_word,
  input  logic [DATA_W-1:0]  rdata,
  output logic               mismatch,
  output logic [BADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0]  fail_exp,
  output logic [DATA_W-1:0]  fail_obs
);
  function automatic logic [BADDR_W-1:0] byte_of(input logic [ADDR_W-1:0] w);
    return {w, {BYTE_SH{1'b0}}};
  endfunction

  assign mismatch = checking && (rdata != expect_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else if (clear) begin
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else if (mismatch) begin
      fail_addr <= byte_of(idx);
      fail_exp  <= expect_word;
      fail_obs  <= rdata;
    end
  end

  assert_report_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mismatch && !clear) |=> ($stable(fail_exp) && $stable(fail_obs) && $stable(fail_addr)))
    else $error("failure report changed without a miscompare");
endmodule

// File: rtl/walk_march_engine.sv
module walk_march_engine #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  localparam int LAST_PASS = DATA_W + 1,
  localparam int PASS_W = $clog2(LAST_PASS + 1),
  localparam int BADDR_W = ADDR_W + $clog2(DATA_W / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W:0]    size_words,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [PASS_W-1:0]  pass_num,
  output logic [BADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0]  fail_exp,
  output logic [DATA_W-1:0]  fail_obs,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  import walk_march_pkg::*;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [PASS_W-1:0] FINAL_P = PASS_W'(LAST_PASS);

  function automatic logic [DATA_W-1:0] expect_for(input logic [PASS_W-1:0] p);
    if (p < PASS_W'(2)) return '0;
    return ONE << (int'(p) - 2);
  endfunction

  function automatic logic [DATA_W-1:0] write_for(input logic [PASS_W-1:0] p);
    if (p <= PASS_W'(1)) return ONE;
    return ONE << (int'(p) - 1);
  endfunction

  march_st_t        st;
  logic [ADDR_W-1:0] idx;
  logic             at_last;
  logic             launch;
  logic             mismatch;
  logic             ctr_clear;
  logic             ctr_step;
  logic             checking;
  logic             last_pass;

  assign launch    = ((st == ST_IDLE) || (st == ST_DONE)) && start;
  assign checking  = (st == ST_CHECK);
  assign last_pass = (pass_num == FINAL_P);

  march_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (ctr_clear),
    .step       (ctr_step),
    .size_words (size_words),
    .idx        (idx),
    .at_last    (at_last)
  );

  march_word_cmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (launch),
    .checking    (checking),
    .idx         (idx),
    .expect_word (expect_for(pass_num)),
    .rdata       (mem_rdata),
    .mismatch    (mismatch),
    .fail_addr   (fail_addr),
    .fail_exp    (fail_exp),
    .fail_obs    (fail_obs)
  );

  always_comb begin
    ctr_clear = launch
             || ((st == ST_FILL) && at_last)
             || (checking && !mismatch && at_last);
    ctr_step  = ((st == ST_FILL) && !at_last)
             || (checking && !mismatch && !at_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pass_num <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            fail <= 1'b0;
            pass_num <= '0;
            if (size_words == '0) begin
              st   <= ST_DONE;
              done <= 1'b1;
            end else begin
              st       <= ST_FILL;
              done     <= 1'b0;
              pass_num <= PASS_W'(1);
            end
          end
        end
        ST_FILL: begin
          if (at_last) begin
            st       <= ST_READ;
            pass_num <= PASS_W'(2);
          end
        end
        ST_READ: st <= ST_CHECK;
        ST_CHECK: begin
          if (mismatch) begin
            st   <= ST_DONE;
            done <= 1'b1;
            fail <= 1'b1;
          end else if (at_last && last_pass) begin
            st   <= ST_DONE;
            done <= 1'b1;
          end else begin
            st <= ST_READ;
            if (at_last) pass_num <= pass_num + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st == ST_FILL) || (st == ST_READ) || checking;
  assign mem_req   = (st == ST_FILL) || (st == ST_READ)
                  || (checking && !mismatch && !last_pass);
  assign mem_we    = (st == ST_FILL) || checking;
  assign mem_addr  = idx;
  assign mem_wdata = write_for(pass_num);

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req) else $error("request while idle");

  assert_fill_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && pass_num == PASS_W'(1) && $past(mem_req && mem_we && pass_num == PASS_W'(1)))
      |-> (mem_addr == $past(mem_addr) + 1'b1)) else $error("pass 1 address not ascending");

  assert_write_same_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && pass_num > PASS_W'(1))
      |-> ($past(mem_req) && !$past(mem_we) && $past(mem_addr) == mem_addr))
    else $error("verify write not preceded by read of the same word");

  assert_last_pass_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && last_pass) |-> !mem_we) else $error("write in final pass");

  assert_no_write_after_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> !mem_req) else $error("request on miscompare");

  assert_done_excl_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)) else $error("done while busy");

  assert_pass_bounds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pass_num >= PASS_W'(1) && pass_num <= FINAL_P)) else $error("pass out of range");
endmodule

// File: tb/walk_march_engine_tb.sv
module walk_march_engine_tb;
  localparam int DW = 64;
  localparam int AW = 6;
  localparam int PW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW:0] size_words = '0;
  logic busy, done, fail, mem_req, mem_we;
  logic [PW-1:0] pass_num;
  logic [AW+2:0] fail_addr;
  logic [DW-1:0] fail_exp, fail_obs, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  walk_march_engine #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_words(size_words),
    .busy(busy), .done(done), .fail(fail), .pass_num(pass_num),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // bench memory with one optional stuck-at fault site
  logic [DW-1:0] mem [0:63];
  int            flt_addr = -1;
  logic [DW-1:0] stuck0 = '0;
  logic [DW-1:0] stuck1 = '0;

  function automatic logic [DW-1:0] faulted(input int a, input logic [DW-1:0] w);
    if (a == flt_addr) return (w & ~stuck0) | stuck1;
    return w;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= faulted(int'(mem_addr), mem_wdata);
      else        mem_rdata <= mem[mem_addr];
    end
  end

  typedef struct {
    bit req;
    bit we;
    int addr;
    logic [DW-1:0] wdata;
    int pnum;
    string tag;
  } cyc_t;

  cyc_t q[$];
  bit            e_fail;
  int            e_pass;
  int            e_addr;
  logic [DW-1:0] e_exp, e_obs;
  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit rq, input bit we, input int a, input logic [DW-1:0] d,
                      input int p, input string t);
    cyc_t c;
    c.req = rq; c.we = we; c.addr = a; c.wdata = d; c.pnum = p; c.tag = t;
    q.push_back(c);
  endtask

  // behavioural model of the whole run: one queue entry per cycle
  task automatic build(input int n);
    logic [DW-1:0] rm [0:63];
    logic [DW-1:0] ex;
    q.delete();
    e_fail = 0; e_pass = 65; e_addr = 0; e_exp = '0; e_obs = '0;
    for (int i = 0; i < n; i++) begin
      push(1, 1, i, 64'd1, 1, "R2 pass1 write");
      rm[i] = faulted(i, 64'd1);
    end
    for (int p = 2; p <= 65; p++) begin
      ex = 64'd1 << (p - 2);
      for (int i = 0; i < n; i++) begin
        push(1, 0, i, '0, p, (p == 65) ? "R4 final read" : "R3 verify read");
        if (rm[i] !== ex) begin
          push(0, 0, i, '0, p, "R5 abort cycle");
          e_fail = 1; e_pass = p; e_addr = i * 8; e_exp = ex; e_obs = rm[i];
          return;
        end
        if (p < 65) begin
          push(1, 1, i, ex << 1, p, "R3 verify write");
          rm[i] = faulted(i, ex << 1);
        end else begin
          push(0, 0, i, '0, p, "R4 final check no write");
        end
      end
    end
  endtask

  task automatic run(input int n, input bit poke, input string name);
    int k;
    size_words = (AW + 1)'(n);
    build(n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0;
    while (q.size() > 0) begin
      cyc_t c;
      c = q.pop_front();
      if (poke && k == 3) start = 1'b1;      // R7 stray start while busy
      if (poke && k == 4) start = 1'b0;
      chk({c.tag, " R9 busy ", name}, 64'(busy), 64'd1);
      chk({c.tag, " R9 done low ", name}, 64'(done), 64'd0);
      chk({c.tag, " R9 fail low ", name}, 64'(fail), 64'd0);
      chk({c.tag, " R10 pass_num ", name}, 64'(pass_num), 64'(c.pnum));
      chk({c.tag, " req ", name}, 64'(mem_req), 64'(c.req));
      if (c.req) begin
        chk({c.tag, " we ", name}, 64'(mem_we), 64'(c.we));
        chk({c.tag, " addr ", name}, 64'(mem_addr), 64'(c.addr));
        if (c.we) chk({c.tag, " wdata ", name}, mem_wdata, c.wdata);
      end
      k++;
      @(negedge clk);
    end
    chk({"R6 done at end ", name}, 64'(done), 64'd1);
    chk({"R9 busy low at end ", name}, 64'(busy), 64'd0);
    chk({"R5 fail flag ", name}, 64'(fail), 64'(e_fail));
    chk({"R5 final pass_num ", name}, 64'(pass_num), 64'(e_pass));
    chk({"R5 no request after end ", name}, 64'(mem_req), 64'd0);
    if (e_fail) begin
      chk({"R5 fail_addr ", name}, 64'(fail_addr), 64'(e_addr));
      chk({"R5 fail_exp ", name}, fail_exp, e_exp);
      chk({"R5 fail_obs ", name}, fail_obs, e_obs);
    end
    repeat (3) @(negedge clk);
    chk({"R9 done held ", name}, 64'(done), 64'd1);
    chk({"R9 fail held ", name}, 64'(fail), 64'(e_fail));
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = {32'hdead0000 + i, 32'h5a5a5a5a};
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 fail after reset", 64'(fail), 64'd0);
    chk("R1 req after reset", 64'(mem_req), 64'd0);
    chk("R1 pass_num after reset", 64'(pass_num), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 empty region
    size_words = '0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R8 done with empty region", 64'(done), 64'd1);
    chk("R8 fail with empty region", 64'(fail), 64'd0);
    chk("R8 busy with empty region", 64'(busy), 64'd0);
    chk("R8 no request with empty region", 64'(mem_req), 64'd0);
    chk("R8 pass_num with empty region", 64'(pass_num), 64'd0);

    run(8, 0, "clean8");
    run(1, 0, "clean1");

    flt_addr = 3; stuck0 = 64'd1; stuck1 = '0;
    run(8, 0, "stuck0_bit0");
    flt_addr = 7; stuck0 = '0; stuck1 = 64'd1 << 40;
    run(8, 0, "stuck1_bit40_last");
    flt_addr = 0; stuck0 = 64'd1 << 63; stuck1 = '0;
    run(5, 0, "stuck0_bit63");
    flt_addr = 2; stuck0 = 64'd1 << 20; stuck1 = '0;
    run(4, 1, "stuck0_bit20_poke");

    flt_addr = -1; stuck0 = '0; stuck1 = '0;
    run(64, 0, "restart_clean64");

    finish_up();
  end
endmodule